// File: doc/BRIEF.md
# Host-Paced UART Ring Byte Swapper

This block joins a serial link to a small circular store inside the chip. The store and a matching buffer in the host together form one long ring. Whenever a complete, well-formed character arrives from the host, the block writes it into the current ring slot. It sends back the byte that slot held just before, then moves on to the next slot. The host therefore decides when every transfer happens. The chip side never sends a character that was not prompted by one it received.

The serial side uses 8N1 framing at one fixed rate. The receiver oversamples each bit sixteen times and confirms a start bit at its middle before it accepts a character. A second, parallel port lets the rest of the chip read and write any ring slot. When that port and a swap reach the ring in the same cycle, the swap takes the ring and the local write is refused.

Top module: `ring_swap_uart`

## Requirements
- R1: After reset the serial output is high (idle), every ring slot holds 8'h00, and the swap position is slot 0.
- R2: Each character received with a high stop bit produces exactly one reply character: a low start bit, 8 data bits LSB first, then a high stop bit, each bit lasting TICK_DIV*OS clocks.
- R3: The reply carries the byte that the current slot held before the swap. The received byte is written into that slot, and the swap position then advances by one.
- R4: The swap position wraps after slot DEPTH-1, so the (DEPTH+1)-th swap uses slot 0 again.
- R5: A character whose stop bit is sampled low is discarded. It produces no reply, leaves the ring unchanged and does not move the swap position.
- R6: A low pulse on the receive line that has gone high again by the middle of the start bit is ignored and produces no reply.
- R7: With no received character, the serial output stays high. The block never starts a transmission on its own.
- R8: A local write with loc_we high and loc_ack high stores loc_wdata in slot loc_addr. loc_rdata shows the contents of slot loc_addr one clock after the address is applied.
- R9: In a cycle that performs a swap, loc_ack is low and a local write presented in that cycle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| uart_rxd | input | 1 | Serial data from the host |
| uart_txd | output | 1 | Serial data to the host |
| loc_addr | input | $clog2(DEPTH) | Local port slot index |
| loc_we | input | 1 | Local write request |
| loc_wdata | input | DW | Local write data |
| loc_ack | output | 1 | Local write accepted this cycle |
| loc_rdata | output | DW | Registered contents of slot loc_addr |

## Verification
A swap and a local write can reach the ring in the same clock cycle. The bench provokes this by holding a local write to the slot due for the next swap through the whole reception of a character. It counts the cycles in which loc_ack is refused, and exactly one must be refused. The reply must carry the locally written value, and the slot must hold that value again once the local write continues after the swap.

// File: rtl/ring_swap_pkg.sv
package ring_swap_pkg;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP,
        RX_BREAK
    } rx_state_e;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_START,
        TX_DATA,
        TX_STOP
    } tx_state_e;

endpackage

// File: rtl/swap_rx.sv
module swap_rx
    import ring_swap_pkg::*;
#(
    parameter int TICK_DIV = 4,
    parameter int OS       = 16,
    parameter int DW       = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rxd_i,
    output logic [DW-1:0] byte_o,
    output logic          valid_o
);
    localparam int TW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam int OW = $clog2(OS);
    localparam int BW = (DW > 1) ? $clog2(DW) : 1;

    typedef struct packed {
        logic [1:0]    sync;
        logic [TW-1:0] div;
        logic [OW-1:0] os;
        logic [BW-1:0] bitn;
        logic [DW-1:0] shreg;
        logic [DW-1:0] data;
        logic          valid;
        rx_state_e     state;
    } rx_reg_t;

    rx_reg_t s_q, s_d;
    logic    line;
    logic    tick;

    always_comb begin
        s_d       = s_q;
        s_d.valid = 1'b0;
        s_d.sync  = {s_q.sync[0], rxd_i};
        line      = s_q.sync[1];
        tick      = (s_q.div == TW'(TICK_DIV - 1));
        s_d.div   = tick ? '0 : s_q.div + 1'b1;
        if (tick) begin
            case (s_q.state)
                RX_IDLE: begin
                    if (!line) begin
                        s_d.state = RX_START;
                        s_d.os    = '0;
                    end
                end
                RX_START: begin
                    if (s_q.os == OW'(OS / 2 - 1)) begin
                        s_d.os   = '0;
                        s_d.bitn = '0;
                        s_d.state = line ? RX_IDLE : RX_DATA;
                    end else begin
                        s_d.os = s_q.os + 1'b1;
                    end
                end
                RX_DATA: begin
                    if (s_q.os == OW'(OS - 1)) begin
                        s_d.os    = '0;
                        s_d.shreg = {line, s_q.shreg[DW-1:1]};
                        if (s_q.bitn == BW'(DW - 1)) begin
                            s_d.state = RX_STOP;
                        end else begin
                            s_d.bitn = s_q.bitn + 1'b1;
                        end
                    end else begin
                        s_d.os = s_q.os + 1'b1;
                    end
                end
                RX_STOP: begin
                    if (s_q.os == OW'(OS - 1)) begin
                        s_d.os = '0;
                        if (line) begin
                            s_d.valid = 1'b1;
                            s_d.data  = s_q.shreg;
                            s_d.state = RX_IDLE;
                        end else begin
                            s_d.state = RX_BREAK;
                        end
                    end else begin
                        s_d.os = s_q.os + 1'b1;
                    end
                end
                RX_BREAK: begin
                    if (line) s_d.state = RX_IDLE;
                end
                default: s_d.state = RX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.sync  <= 2'b11;
            s_q.state <= RX_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign byte_o  = s_q.data;
    assign valid_o = s_q.valid;

    // R2
    rx_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    // R5
    rx_break_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.state == RX_BREAK) |-> !valid_o);

endmodule

// File: rtl/swap_tx.sv
module swap_tx
    import ring_swap_pkg::*;
#(
    parameter int BIT_CLKS = 64,
    parameter int DW       = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [DW-1:0] data_i,
    output logic          busy_o,
    output logic          txd_o
);
    localparam int CW = (BIT_CLKS > 1) ? $clog2(BIT_CLKS) : 1;
    localparam int BW = (DW > 1) ? $clog2(DW) : 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [BW-1:0] bitn;
        logic [DW-1:0] shreg;
        logic          txd;
        tx_state_e     state;
    } tx_reg_t;

    tx_reg_t s_q, s_d;
    logic    done;

    always_comb begin
        s_d  = s_q;
        done = (s_q.cnt == CW'(BIT_CLKS - 1));
        s_d.cnt = done ? '0 : s_q.cnt + 1'b1;
        case (s_q.state)
            TX_IDLE: begin
                s_d.cnt = '0;
                s_d.txd = 1'b1;
                if (load_i) begin
                    s_d.shreg = data_i;
                    s_d.state = TX_START;
                    s_d.txd   = 1'b0;
                end
            end
            TX_START: begin
                if (done) begin
                    s_d.state = TX_DATA;
                    s_d.bitn  = '0;
                    s_d.txd   = s_q.shreg[0];
                end
            end
            TX_DATA: begin
                if (done) begin
                    if (s_q.bitn == BW'(DW - 1)) begin
                        s_d.state = TX_STOP;
                        s_d.txd   = 1'b1;
                    end else begin
                        s_d.bitn  = s_q.bitn + 1'b1;
                        s_d.shreg = s_q.shreg >> 1;
                        s_d.txd   = s_q.shreg[1];
                    end
                end
            end
            TX_STOP: begin
                if (done) s_d.state = TX_IDLE;
            end
            default: s_d.state = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.txd   <= 1'b1;
            s_q.state <= TX_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy_o = (s_q.state != TX_IDLE);
    assign txd_o  = s_q.txd;

    // R7
    tx_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !load_i) |=> txd_o);

    // R2
    tx_start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> !txd_o);

endmodule

// File: rtl/swap_ring.sv
module swap_ring #(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          swap_i,
    input  logic [DW-1:0] swap_wdata_i,
    output logic [DW-1:0] swap_rdata_o,
    input  logic [AW-1:0] loc_addr_i,
    input  logic          loc_we_i,
    input  logic [DW-1:0] loc_wdata_i,
    output logic          loc_ack_o,
    output logic [DW-1:0] loc_rdata_o
);
    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] mem;
        logic [AW-1:0]            rd_ptr;
        logic [AW-1:0]            wr_ptr;
        logic [DW-1:0]            lrd;
    } ring_reg_t;

    ring_reg_t s_q, s_d;

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        s_d       = s_q;
        loc_ack_o = loc_we_i && !swap_i;
        if (swap_i) begin
            s_d.mem[s_q.wr_ptr] = swap_wdata_i;
            s_d.rd_ptr          = step(s_q.rd_ptr);
            s_d.wr_ptr          = step(s_q.wr_ptr);
        end else if (loc_we_i) begin
            s_d.mem[loc_addr_i] = loc_wdata_i;
        end
        s_d.lrd = s_q.mem[loc_addr_i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign swap_rdata_o = s_q.mem[s_q.rd_ptr];
    assign loc_rdata_o  = s_q.lrd;

    // R3
    ring_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        swap_i |=> s_q.mem[$past(s_q.wr_ptr)] == $past(swap_wdata_i));

    // R4
    ring_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (swap_i && s_q.rd_ptr == AW'(DEPTH - 1)) |=> (s_q.rd_ptr == '0));

    // R8
    loc_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        loc_ack_o |=> s_q.mem[$past(loc_addr_i)] == $past(loc_wdata_i));

    // R9
    loc_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (swap_i && loc_we_i && loc_addr_i != s_q.wr_ptr)
        |=> s_q.mem[$past(loc_addr_i)] == $past(s_q.mem[loc_addr_i]));

endmodule

// File: rtl/ring_swap_uart.sv
module ring_swap_uart #(
    parameter int TICK_DIV = 4,
    parameter int OS       = 16,
    parameter int DEPTH    = 16,
    parameter int DW       = 8,
    localparam int AW      = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          uart_rxd,
    output logic          uart_txd,
    input  logic [AW-1:0] loc_addr,
    input  logic          loc_we,
    input  logic [DW-1:0] loc_wdata,
    output logic          loc_ack,
    output logic [DW-1:0] loc_rdata
);
    localparam int BIT_CLKS = TICK_DIV * OS;

    typedef struct packed {
        logic          pend;
        logic [DW-1:0] pend_data;
    } top_reg_t;

    top_reg_t      s_q, s_d;
    logic [DW-1:0] rx_byte;
    logic          rx_valid;
    logic [DW-1:0] ring_out;
    logic          tx_busy;
    logic          tx_load;

    swap_rx #(.TICK_DIV(TICK_DIV), .OS(OS), .DW(DW)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .rxd_i   (uart_rxd),
        .byte_o  (rx_byte),
        .valid_o (rx_valid)
    );

    swap_ring #(.DEPTH(DEPTH), .DW(DW)) u_ring (
        .clk          (clk),
        .rst_n        (rst_n),
        .swap_i       (rx_valid),
        .swap_wdata_i (rx_byte),
        .swap_rdata_o (ring_out),
        .loc_addr_i   (loc_addr),
        .loc_we_i     (loc_we),
        .loc_wdata_i  (loc_wdata),
        .loc_ack_o    (loc_ack),
        .loc_rdata_o  (loc_rdata)
    );

    always_comb begin
        s_d     = s_q;
        tx_load = s_q.pend && !tx_busy;
        if (tx_load) s_d.pend = 1'b0;
        if (rx_valid) begin
            s_d.pend      = 1'b1;
            s_d.pend_data = ring_out;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    swap_tx #(.BIT_CLKS(BIT_CLKS), .DW(DW)) u_tx (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (tx_load),
        .data_i (s_q.pend_data),
        .busy_o (tx_busy),
        .txd_o  (uart_txd)
    );

    // R2
    reply_queued_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> s_q.pend);

    // R7
    reply_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_busy) |-> $past(s_q.pend));

endmodule

// File: tb/ring_swap_uart_bench.sv
module ring_swap_uart_bench;
    localparam int CLK_PERIOD = 10;
    localparam int TICK_DIV   = 4;
    localparam int OS         = 16;
    localparam int DEPTH      = 16;
    localparam int DW         = 8;
    localparam int AW         = $clog2(DEPTH);
    localparam int BITC       = TICK_DIV * OS;

    localparam logic [7:0] RX_VEC [16] = '{
        8'h3E, 8'h01, 8'hFE, 8'h80, 8'h55, 8'hAA, 8'h0F, 8'hF0,
        8'h12, 8'h9C, 8'h61, 8'hD7, 8'h44, 8'hB8, 8'h2D, 8'hE3
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          uart_rxd = 1'b1;
    logic          uart_txd;
    logic [AW-1:0] loc_addr = '0;
    logic          loc_we = 1'b0;
    logic [DW-1:0] loc_wdata = '0;
    logic          loc_ack;
    logic [DW-1:0] loc_rdata;

    int checks = 0;
    int errors = 0;
    int drops  = 0;
    logic mon_en = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ring_swap_uart #(.TICK_DIV(TICK_DIV), .OS(OS), .DEPTH(DEPTH), .DW(DW)) u_ring_swap_uart (
        .clk(clk), .rst_n(rst_n), .uart_rxd(uart_rxd), .uart_txd(uart_txd),
        .loc_addr(loc_addr), .loc_we(loc_we), .loc_wdata(loc_wdata),
        .loc_ack(loc_ack), .loc_rdata(loc_rdata)
    );

    always @(posedge clk) begin
        #2;
        if (mon_en && loc_we && !loc_ack) drops++;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] b, input logic stop);
        @(negedge clk);
        uart_rxd = 1'b0;
        repeat (BITC) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            uart_rxd = b[i];
            repeat (BITC) @(negedge clk);
        end
        uart_rxd = stop;
        repeat (BITC) @(negedge clk);
        uart_rxd = 1'b1;
    endtask

    task automatic get_reply(output logic [7:0] b, output logic got);
        int waited = 0;
        got = 1'b0;
        b = '0;
        while (uart_txd && waited < 1500) begin
            @(negedge clk);
            waited++;
        end
        if (!uart_txd) begin
            repeat (BITC / 2) @(negedge clk);
            if (!uart_txd) begin
                for (int i = 0; i < 8; i++) begin
                    repeat (BITC) @(negedge clk);
                    b[i] = uart_txd;
                end
                repeat (BITC) @(negedge clk);
                got = uart_txd;
            end
        end
    endtask

    task automatic swap(input logic [7:0] tx, input logic stop,
                        output logic [7:0] rep, output logic got);
        fork
            send(tx, stop);
            get_reply(rep, got);
        join
    endtask

    task automatic loc_read(input int a, output logic [7:0] d);
        @(negedge clk);
        loc_addr = AW'(a);
        @(negedge clk);
        d = loc_rdata;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] rep;
        logic       got;
        logic [7:0] d;
        int         lowcnt;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 reset state
        chk("R1 txd idle", uart_txd, 1);
        loc_read(7, d);
        chk("R1 slot zero", d, 0);

        // R8 preload through local port, read back
        for (int k = 0; k < DEPTH; k++) begin
            @(negedge clk);
            loc_addr = AW'(k);
            loc_wdata = 8'hA0 + 8'(k);
            loc_we = 1'b1;
        end
        @(negedge clk);
        loc_we = 1'b0;
        for (int k = 0; k < DEPTH; k++) begin
            loc_read(k, d);
            chk("R8 local readback", d, 8'hA0 + k);
        end

        // R2 R3 table walk: each reply is old slot content
        for (int k = 0; k < 16; k++) begin
            swap(RX_VEC[k], 1'b1, rep, got);
            chk("R2 reply present", got, 1);
            chk("R3 reply old slot", rep, 8'hA0 + k);
        end

        // R4 wrap: slot 0 reused
        swap(8'h5A, 1'b1, rep, got);
        chk("R4 wrap reply", rep, RX_VEC[0]);

        // R5 bad stop bit
        swap(8'h99, 1'b0, rep, got);
        chk("R5 no reply on bad stop", got, 0);
        swap(8'h77, 1'b1, rep, got);
        chk("R5 pointer unmoved", rep, RX_VEC[1]);

        // R6 short glitch
        fork
            begin
                @(negedge clk);
                uart_rxd = 1'b0;
                repeat (10) @(negedge clk);
                uart_rxd = 1'b1;
            end
            get_reply(rep, got);
        join
        chk("R6 glitch ignored", got, 0);

        // R7 quiet line
        lowcnt = 0;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (!uart_txd) lowcnt++;
        end
        chk("R7 txd stays high", lowcnt, 0);

        // R9 collision: local write held on the slot the swap uses (slot 2)
        @(negedge clk);
        loc_addr = AW'(2);
        loc_wdata = 8'h3C;
        loc_we = 1'b1;
        drops = 0;
        mon_en = 1'b1;
        swap(8'hC3, 1'b1, rep, got);
        @(negedge clk);
        mon_en = 1'b0;
        loc_we = 1'b0;
        chk("R9 single refused cycle", drops, 1);
        chk("R9 reply local value", rep, 8'h3C);
        loc_read(2, d);
        chk("R9 slot after collision", d, 8'h3C);

        // R3 stores of earlier swaps
        loc_read(0, d);
        chk("R3 slot0 stored", d, 8'h5A);
        loc_read(1, d);
        chk("R3 slot1 stored", d, 8'h77);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule